// File: doc/BRIEF.md
# Pipelined Serial ADC Scan Sequencer

This block is the controller for a 12-bit-plus-sign converter that sits on a serial peripheral bus. When reset is released it prepares the converter on its own. It commands self-calibration and then clears the stale data with one status read. Next it waits for the converter to signal end of conversion and reads status again, to confirm that calibration has finished. Last, it programs the sample-and-hold acquisition time that the configuration inputs select.

When a trigger arrives, the block converts every entry set in a 16-bit scan mask, starting from the lowest index. Entries 0 to 7 select single-ended channels 0 to 7. Entries 8 to 15 select differential pairs. The conversions are pipelined: each two-byte transfer starts the next conversion and, in the same transfer, clocks in the result of the one before. A closing status read collects the result of the last channel. Each result is written out, sign-extended, on a write port together with its scan index.

If the converter stays silent after a conversion, a timeout aborts the scan and raises the error output. A failed calibration check or an unsupported acquisition time stops the block until the next reset.

Top module: `adc_scan_seq`

## Requirements
- R1: After reset the block makes the following transfers in order, with no other transfers between them:
  - a one-byte calibrate command 0x08;
  - a two-byte status read 0x0C whose data is ignored;
  - a wait for a rising edge on `eoc_i` (or the timeout, after which it carries on);
  - a second two-byte status read 0x0C;
  - a one-byte acquisition-time command.

  `busy_o` is high from reset until this sequence completes.
- R2: `acq_clocks_i` selects the acquisition command: 6 gives 0x0E, 10 gives 0x4E, 18 gives 0x8E, 34 gives 0xCE, and 0 gives the 10-clock default 0x4E. Any other value sends no acquisition command, sets `error_o`, and leaves the block ignoring triggers until reset.
- R3: The status word is the 9-bit value (byte0 << 1) | (byte1 >> 7) taken from the second status read. If its bit 6 (calibration busy) is set, `error_o` goes high, no acquisition command is sent, and triggers are ignored until reset.
- R4: A scan visits the set mask bits in ascending order. The conversion mode byte is {se, mux[2:0], 4'b0000}:
  - mask bit s < 8 converts single-ended channel s, with se = 1;
  - mask bit s >= 8 converts the differential pair that starts at channel k = s-8, with se = 0;
  - mux is taken from channel s or k by the map 0→0, 1→4, 2→1, 3→5, 4→2, 5→6, 6→3, 7→7.
- R5: With `small_variant_i` = 1, every command byte m is sent as {m[7:6], m[3:0], 2'b00}.
- R6: Every conversion transfer is two bytes long. The data returned by the first transfer of a scan is discarded, and each later transfer returns the result for the previous enabled entry. After the last entry, a two-byte status read 0x0C returns its result. Each result appears for one cycle on `res_we_o`, with `res_idx_o` set to that entry's scan index.
- R7: `res_data_o` is the 16 received bits, taken MSB first and shifted right by 3, with the 13-bit value sign-extended to 16 bits.
- R8: After each conversion transfer the block waits for a rising edge on `eoc_i`. If none arrives within EOC_TIMEOUT cycles:
  - the scan stops with no further transfer;
  - `error_o` is set and `done_o` pulses;
  - `error_o` clears when the next trigger is accepted.
- R9: The bus runs in mode 0 with the MSB first. `cs_no` is low for all bytes of one transfer and high between transfers, and `sclk_o` is low whenever `cs_no` is high. Under reset, `cs_no` = 1, `sclk_o` = 0, `done_o` = 0, `res_we_o` = 0 and `error_o` = 0.
- R10: A trigger with an all-zero mask makes `done_o` pulse with no transfer. The mask is captured when the trigger is accepted, so later changes to `scan_mask_i` do not affect the running scan.
- R11: `busy_o` is high from an accepted trigger until `done_o`. `done_o` is a one-cycle pulse, and a trigger that arrives while `busy_o` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| trigger_i | input | 1 | Starts a scan when the block is idle |
| scan_mask_i | input | 16 | Entries to convert: 0-7 single-ended, 8-15 differential |
| small_variant_i | input | 1 | Selects the command-byte remap for the smaller converter |
| acq_clocks_i | input | 6 | Acquisition time in converter clocks (0 selects the default) |
| eoc_i | input | 1 | End-of-conversion from the converter (asynchronous) |
| busy_o | output | 1 | High during initialisation or a scan |
| done_o | output | 1 | One-cycle pulse when a scan ends |
| error_o | output | 1 | Timeout, calibration or configuration error |
| res_we_o | output | 1 | Result write strobe |
| res_idx_o | output | 4 | Scan index of the result being written |
| res_data_o | output | 16 | Sign-extended result |
| sclk_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data to the converter |
| miso_i | input | 1 | Serial data from the converter |
| cs_no | output | 1 | Active-low chip select |

## Verification
The assertions check the following on every cycle:
- the bus idles with `sclk_o` low and `mosi_o` holds steady across each rising `sclk_o` edge;
- chip select only falls while the block is busy;
- `done_o` is a single pulse;
- a timeout always ends in an idle state with `error_o` set;
- a failure state is never left;
- every write targets an entry of the captured mask;
- a trigger during a scan leaves that mask untouched.

Only the bench scenarios, played against a converter model, can show the rest:
- the command bytes and their order;
- the pipelined pairing of each returned result with the previous entry;
- the remap for the smaller variant;
- the values of the sign-extended results.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;
  localparam int DATA_W = 13;
  localparam int WORD_W = 16;

  typedef enum logic [1:0] {
    CMD_CAL,
    CMD_STAT,
    CMD_ACQ,
    CMD_CONV
  } cmd_kind_e;

  typedef enum logic [3:0] {
    ST_CAL,
    ST_STAT1,
    ST_CALWAIT,
    ST_STAT2,
    ST_ACQ,
    ST_IDLE,
    ST_CONV,
    ST_EOC,
    ST_LAST,
    ST_FAIL
  } seq_state_e;
endpackage

// File: rtl/adc_mode_enc.sv
module adc_mode_enc
  import adc_scan_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  cmd_kind_e        kind_i,
  input  logic [IDX_W-1:0] ch_i,
  input  logic [5:0]       acq_clocks_i,
  input  logic             small_i,
  output logic [7:0]       mode_o,
  output logic             acq_ok_o
);
  logic [7:0] raw;
  logic [7:0] acq_byte;
  logic [2:0] k;

  assign k = ch_i[2:0];

  always_comb begin
    acq_ok_o = 1'b1;
    case (acq_clocks_i)
      6'd0, 6'd10: acq_byte = 8'h4E;
      6'd6:        acq_byte = 8'h0E;
      6'd18:       acq_byte = 8'h8E;
      6'd34:       acq_byte = 8'hCE;
      default: begin
        acq_byte = 8'h4E;
        acq_ok_o = 1'b0;
      end
    endcase
  end

  always_comb begin
    case (kind_i)
      CMD_CAL:  raw = 8'h08;
      CMD_STAT: raw = 8'h0C;
      CMD_ACQ:  raw = acq_byte;
      default:  raw = {~ch_i[IDX_W-1], k[0], k[2:1], 4'b0000};
    endcase
  end

  // smaller variant drops bits 5:4 and shifts the low nibble up
  assign mode_o = small_i ? {raw[7:6], raw[3:0], 2'b00} : raw;
endmodule

// File: rtl/adc_spi_xfer.sv
module adc_spi_xfer #(
  parameter int CLK_DIV = 4
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  input  logic        two_byte_i,
  input  logic [7:0]  tx_i,
  output logic        done_o,
  output logic [15:0] rx_o,
  output logic        sclk_o,
  output logic        mosi_o,
  input  logic        miso_i,
  output logic        cs_no
);
  localparam int DIV_W = $clog2(CLK_DIV + 1);

  logic             active;
  logic [DIV_W-1:0] div_cnt;
  logic [3:0]       bit_cnt;
  logic [3:0]       last_bit;
  logic [7:0]       tx_sh;
  logic [15:0]      rx_sh;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active   <= 1'b0;
      div_cnt  <= '0;
      bit_cnt  <= '0;
      last_bit <= '0;
      tx_sh    <= '0;
      rx_sh    <= '0;
      sclk_o   <= 1'b0;
      done_o   <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (!active) begin
        if (start_i) begin
          active   <= 1'b1;
          div_cnt  <= '0;
          bit_cnt  <= '0;
          last_bit <= two_byte_i ? 4'd15 : 4'd7;
          tx_sh    <= tx_i;
          rx_sh    <= '0;
        end
      end else if (div_cnt == DIV_W'(CLK_DIV - 1)) begin
        div_cnt <= '0;
        if (!sclk_o) begin
          sclk_o <= 1'b1;
          rx_sh  <= {rx_sh[14:0], miso_i};
        end else begin
          sclk_o <= 1'b0;
          if (bit_cnt == last_bit) begin
            active <= 1'b0;
            done_o <= 1'b1;
          end else begin
            bit_cnt <= bit_cnt + 4'd1;
            tx_sh   <= {tx_sh[6:0], 1'b0};
          end
        end
      end else begin
        div_cnt <= div_cnt + DIV_W'(1);
      end
    end
  end

  assign cs_no  = ~active;
  assign mosi_o = active & tx_sh[7];
  assign rx_o   = rx_sh;

  p_sclk_idle_low_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_no |-> !sclk_o);
  p_mosi_setup_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sclk_o) |-> $stable(mosi_o));
endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
  import adc_scan_pkg::*;
#(
  parameter int CLK_DIV     = 4,
  parameter int EOC_TIMEOUT = 50000,
  parameter int N_CH        = 8
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     trigger_i,
  input  logic [2*N_CH-1:0]        scan_mask_i,
  input  logic                     small_variant_i,
  input  logic [5:0]               acq_clocks_i,
  input  logic                     eoc_i,
  output logic                     busy_o,
  output logic                     done_o,
  output logic                     error_o,
  output logic                     res_we_o,
  output logic [$clog2(2*N_CH)-1:0] res_idx_o,
  output logic [WORD_W-1:0]        res_data_o,
  output logic                     sclk_o,
  output logic                     mosi_o,
  input  logic                     miso_i,
  output logic                     cs_no
);
  localparam int N_SCAN = 2 * N_CH;
  localparam int IDX_W  = $clog2(N_SCAN);
  localparam int TMO_W  = $clog2(EOC_TIMEOUT + 1);
  localparam int EXT_W  = WORD_W - DATA_W;

  seq_state_e        state;
  logic              launched;
  logic              first;
  logic [N_SCAN-1:0] mask_r;
  logic [N_SCAN-1:0] remain;
  logic [IDX_W-1:0]  cur_ch;
  logic [IDX_W-1:0]  prev_ch;
  logic [TMO_W-1:0]  tmo_cnt;
  logic              tmo_hit;
  logic [2:0]        eoc_sync;
  logic              eoc_rise;

  cmd_kind_e         kind;
  logic              two_byte;
  logic              is_cmd;
  logic              xfer_start;
  logic              xfer_done;
  logic [15:0]       rx_word;
  logic [7:0]        mode_byte;
  logic              acq_ok;
  logic [8:0]        stat_word;

  // lowest pending entry
  always_comb begin
    cur_ch = '0;
    for (int i = N_SCAN - 1; i >= 0; i--) begin
      if (remain[i]) cur_ch = IDX_W'(i);
    end
  end

  always_comb begin
    kind     = CMD_STAT;
    two_byte = 1'b1;
    is_cmd   = 1'b0;
    case (state)
      ST_CAL:   begin kind = CMD_CAL; two_byte = 1'b0; is_cmd = 1'b1; end
      ST_ACQ:   begin kind = CMD_ACQ; two_byte = 1'b0; is_cmd = 1'b1; end
      ST_CONV:  begin kind = CMD_CONV; is_cmd = 1'b1; end
      ST_STAT1, ST_STAT2, ST_LAST: is_cmd = 1'b1;
      default: ;
    endcase
  end

  assign xfer_start = is_cmd & ~launched;
  assign stat_word  = {rx_word[15:8], rx_word[7]};
  assign tmo_hit    = (tmo_cnt == TMO_W'(EOC_TIMEOUT - 1));
  assign eoc_rise   = eoc_sync[1] & ~eoc_sync[2];
  assign busy_o     = (state != ST_IDLE) && (state != ST_FAIL);

  adc_mode_enc #(.IDX_W(IDX_W)) u_enc (
    .kind_i       (kind),
    .ch_i         (cur_ch),
    .acq_clocks_i (acq_clocks_i),
    .small_i      (small_variant_i),
    .mode_o       (mode_byte),
    .acq_ok_o     (acq_ok)
  );

  adc_spi_xfer #(.CLK_DIV(CLK_DIV)) u_spi (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (xfer_start),
    .two_byte_i (two_byte),
    .tx_i       (mode_byte),
    .done_o     (xfer_done),
    .rx_o       (rx_word),
    .sclk_o     (sclk_o),
    .mosi_o     (mosi_o),
    .miso_i     (miso_i),
    .cs_no      (cs_no)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) eoc_sync <= '0;
    else         eoc_sync <= {eoc_sync[1:0], eoc_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state      <= ST_CAL;
      launched   <= 1'b0;
      first      <= 1'b0;
      mask_r     <= '0;
      remain     <= '0;
      prev_ch    <= '0;
      tmo_cnt    <= '0;
      done_o     <= 1'b0;
      error_o    <= 1'b0;
      res_we_o   <= 1'b0;
      res_idx_o  <= '0;
      res_data_o <= '0;
    end else begin
      done_o   <= 1'b0;
      res_we_o <= 1'b0;
      if (xfer_start) launched <= 1'b1;
      if (xfer_done)  launched <= 1'b0;
      case (state)
        ST_CAL: if (xfer_done) state <= ST_STAT1;
        ST_STAT1: if (xfer_done) begin
          tmo_cnt <= '0;
          state   <= ST_CALWAIT;
        end
        ST_CALWAIT: begin
          if (eoc_rise || tmo_hit) state <= ST_STAT2;
          else tmo_cnt <= tmo_cnt + TMO_W'(1);
        end
        ST_STAT2: if (xfer_done) begin
          if (stat_word[6] || !acq_ok) begin
            error_o <= 1'b1;
            state   <= ST_FAIL;
          end else begin
            state <= ST_ACQ;
          end
        end
        ST_ACQ: if (xfer_done) state <= ST_IDLE;
        ST_IDLE: if (trigger_i) begin
          error_o <= 1'b0;
          mask_r  <= scan_mask_i;
          remain  <= scan_mask_i;
          first   <= 1'b1;
          if (scan_mask_i == '0) done_o <= 1'b1;
          else                   state  <= ST_CONV;
        end
        ST_CONV: if (xfer_done) begin
          if (!first) begin
            res_we_o   <= 1'b1;
            res_idx_o  <= prev_ch;
            res_data_o <= {{EXT_W{rx_word[15]}}, rx_word[15:EXT_W]};
          end
          first          <= 1'b0;
          prev_ch        <= cur_ch;
          remain[cur_ch] <= 1'b0;
          tmo_cnt        <= '0;
          state          <= ST_EOC;
        end
        ST_EOC: begin
          if (eoc_rise) begin
            state <= (remain != '0) ? ST_CONV : ST_LAST;
          end else if (tmo_hit) begin
            error_o <= 1'b1;
            done_o  <= 1'b1;
            state   <= ST_IDLE;
          end else begin
            tmo_cnt <= tmo_cnt + TMO_W'(1);
          end
        end
        ST_LAST: if (xfer_done) begin
          res_we_o   <= 1'b1;
          res_idx_o  <= prev_ch;
          res_data_o <= {{EXT_W{rx_word[15]}}, rx_word[15:EXT_W]};
          done_o     <= 1'b1;
          state      <= ST_IDLE;
        end
        default: state <= ST_FAIL;
      endcase
    end
  end

  p_cs_when_busy_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cs_no) |-> busy_o);
  p_done_single_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_busy_trig_keeps_mask_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && trigger_i) |=> $stable(mask_r));
  p_timeout_abort_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_EOC && tmo_hit && !eoc_rise) |=> (error_o && done_o && !busy_o));
  p_fail_sticky_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_FAIL) |=> (state == ST_FAIL && error_o && !busy_o));
  p_write_in_mask_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_we_o |-> mask_r[res_idx_o]);
endmodule

// File: tb/tb_adc_scan_seq.sv
module tb_adc_scan_seq;
  localparam int CLK_DIV = 2;
  localparam int TMO     = 300;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        trigger = 1'b0;
  logic [15:0] scan_mask = '0;
  logic        small_var = 1'b0;
  logic [5:0]  acq_clocks = 6'd10;
  logic        eoc = 1'b0;
  logic        busy, done, error, res_we;
  logic [3:0]  res_idx;
  logic [15:0] res_data;
  logic        sclk, mosi, cs_n;
  logic        miso = 1'b0;

  always #10 clk = ~clk;

  adc_scan_seq #(.CLK_DIV(CLK_DIV), .EOC_TIMEOUT(TMO), .N_CH(8)) dut (
    .clk_i(clk), .rst_ni(rst_n), .trigger_i(trigger), .scan_mask_i(scan_mask),
    .small_variant_i(small_var), .acq_clocks_i(acq_clocks), .eoc_i(eoc),
    .busy_o(busy), .done_o(done), .error_o(error), .res_we_o(res_we),
    .res_idx_o(res_idx), .res_data_o(res_data), .sclk_o(sclk), .mosi_o(mosi),
    .miso_i(miso), .cs_no(cs_n)
  );

  int n_checks = 0;
  int n_err = 0;

  // converter model state
  logic [7:0]  log_b0 [0:1023];
  int          log_nb [0:1023];
  logic [12:0] exp_val [0:1023];
  logic [3:0]  w_idx [0:1023];
  logic [15:0] w_dat [0:1023];
  int n_log = 0, n_conv = 0, n_w = 0, n_done = 0;
  int drop_at = -1;
  bit cal_stuck = 1'b0;
  int cal_phase = 0;
  logic [15:0] out_word = 16'h1234;
  logic [15:0] rxs;
  int nb, bitpos, eoc_cnt = 0;
  logic prev_cs = 1'b1, prev_sclk = 1'b0;

  function automatic logic [7:0] remap(input logic [7:0] m, input bit sm);
    return sm ? {m[7:6], m[3:0], 2'b00} : m;
  endfunction

  function automatic logic [7:0] conv_byte(input int s);
    logic [2:0] mx;
    case (s % 8)
      0: mx = 3'd0; 1: mx = 3'd4; 2: mx = 3'd1; 3: mx = 3'd5;
      4: mx = 3'd2; 5: mx = 3'd6; 6: mx = 3'd3; default: mx = 3'd7;
    endcase
    return {(s < 8) ? 1'b1 : 1'b0, mx, 4'b0000};
  endfunction

  function automatic logic [7:0] acq_byte(input int a);
    case (a)
      6: return 8'h0E; 18: return 8'h8E; 34: return 8'hCE; default: return 8'h4E;
    endcase
  endfunction

  function automatic bit is_conv(input logic [7:0] b, input bit sm);
    if (sm) return b[5:0] == 6'd0;
    return b[3:0] == 4'd0;
  endfunction

  always @(negedge clk) begin
    if (eoc_cnt > 0) eoc_cnt <= eoc_cnt - 1;
    eoc <= (eoc_cnt > 0 && eoc_cnt <= 4);
    if (prev_cs && !cs_n) begin
      bitpos = 15; miso <= out_word[15]; nb = 0; rxs = '0;
    end
    if (!cs_n && !prev_sclk && sclk) begin
      rxs = {rxs[14:0], mosi}; nb++;
    end
    if (!cs_n && prev_sclk && !sclk && bitpos > 0) begin
      bitpos--; miso <= out_word[bitpos];
    end
    if (!prev_cs && cs_n) begin
      logic [7:0] b0;
      b0 = (nb > 8) ? rxs[15:8] : rxs[7:0];
      log_b0[n_log & 1023] = b0;
      log_nb[n_log & 1023] = nb;
      n_log++;
      if (b0 == remap(8'h08, small_var)) begin
        out_word = 16'h1234; cal_phase = 1; eoc_cnt <= 154;
      end else if (b0 == remap(8'h0C, small_var) && cal_phase == 1) begin
        out_word = cal_stuck ? 16'h2000 : 16'hDF80; cal_phase = 2;
      end else if (is_conv(b0, small_var)) begin
        logic [12:0] smp;
        smp = 13'($urandom);
        exp_val[n_conv & 1023] = smp;
        out_word = {smp, 3'b101};
        if (n_conv != drop_at) eoc_cnt <= 44;
        n_conv++;
      end else begin
        out_word = 16'hA5A5;
      end
    end
    if (res_we) begin
      w_idx[n_w & 1023] = res_idx; w_dat[n_w & 1023] = res_data; n_w++;
    end
    if (done) n_done++;
    prev_cs = cs_n; prev_sclk = sclk;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_idle();
    int lim = 0;
    while (busy && lim < 20000) begin @(negedge clk); lim++; end
    repeat (3) @(negedge clk);
  endtask

  task automatic do_reset(input bit sm, input int acq, input bit stuck, input bit expect_ok);
    int base;
    @(negedge clk);
    rst_n = 1'b0; small_var = sm; acq_clocks = 6'(acq); cal_stuck = stuck;
    repeat (3) @(negedge clk);
    chk(cs_n == 1 && sclk == 0 && done == 0 && res_we == 0 && error == 0,
        "R9 reset state", {cs_n, sclk, done, res_we, error}, 5'b10000);
    base = n_log;
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 1, "R1 busy during init", busy, 1);
    wait_idle();
    if (expect_ok) begin
      chk(n_log - base == 4, "R1 init transfer count", n_log - base, 4);
      chk(log_b0[base & 1023] == remap(8'h08, sm) && log_nb[base & 1023] == 8,
          "R1 R5 calibrate byte", log_b0[base & 1023], remap(8'h08, sm));
      chk(log_b0[(base+1) & 1023] == remap(8'h0C, sm) && log_nb[(base+1) & 1023] == 16,
          "R1 first status", log_b0[(base+1) & 1023], remap(8'h0C, sm));
      chk(log_b0[(base+2) & 1023] == remap(8'h0C, sm) && log_nb[(base+2) & 1023] == 16,
          "R1 second status", log_b0[(base+2) & 1023], remap(8'h0C, sm));
      chk(log_b0[(base+3) & 1023] == remap(acq_byte(acq), sm) && log_nb[(base+3) & 1023] == 8,
          "R2 R5 acquisition byte", log_b0[(base+3) & 1023], remap(acq_byte(acq), sm));
      chk(error == 0, "R3 no error after init", error, 0);
    end else begin
      chk(n_log - base == 3, "R2 R3 no acquisition transfer", n_log - base, 3);
      chk(error == 1, "R2 R3 error raised", error, 1);
    end
  endtask

  task automatic run_scan(input logic [15:0] m, input bit interfere, input bit expect_to);
    int bl, bc, bw, bd, lim, cnt, k;
    bl = n_log; bc = n_conv; bw = n_w; bd = n_done;
    @(negedge clk);
    scan_mask = m; trigger = 1'b1;
    @(negedge clk);
    trigger = 1'b0;
    if (m != 0) begin
      chk(busy == 1, "R11 busy after trigger", busy, 1);
      chk(error == 0, "R8 error cleared by trigger", error, 0);
    end
    lim = 0;
    while (n_done == bd && lim < 20000) begin
      @(negedge clk); lim++;
      if (interfere && lim == 90) begin
        scan_mask = ~m; trigger = 1'b1;
      end
      if (interfere && lim == 91) trigger = 1'b0;
    end
    repeat (3) @(negedge clk);
    chk(n_done - bd == 1, "R11 single done", n_done - bd, 1);
    chk(busy == 0, "R11 idle after done", busy, 0);
    if (expect_to) return;
    cnt = 0;
    for (int s = 0; s < 16; s++) if (m[s]) cnt++;
    chk(error == 0, "R8 no error", error, 0);
    chk(n_conv - bc == cnt, "R4 conversion count", n_conv - bc, cnt);
    chk(n_w - bw == cnt, "R6 write count", n_w - bw, cnt);
    if (cnt == 0) begin
      chk(n_log == bl, "R10 empty mask no transfer", n_log - bl, 0);
      return;
    end
    chk(n_log - bl == cnt + 1, "R6 transfer count", n_log - bl, cnt + 1);
    k = 0;
    for (int s = 0; s < 16; s++) begin
      if (m[s]) begin
        chk(log_b0[(bl+k) & 1023] == remap(conv_byte(s), small_var) && log_nb[(bl+k) & 1023] == 16,
            "R4 R5 conversion mode byte", log_b0[(bl+k) & 1023], remap(conv_byte(s), small_var));
        chk(w_idx[(bw+k) & 1023] == 4'(s), "R6 result index", w_idx[(bw+k) & 1023], s);
        chk(w_dat[(bw+k) & 1023] == {{3{exp_val[(bc+k) & 1023][12]}}, exp_val[(bc+k) & 1023]},
            "R7 result data", w_dat[(bw+k) & 1023],
            {{3{exp_val[(bc+k) & 1023][12]}}, exp_val[(bc+k) & 1023]});
        k++;
      end
    end
    chk(log_b0[(bl+cnt) & 1023] == remap(8'h0C, small_var) && log_nb[(bl+cnt) & 1023] == 16,
        "R6 closing status read", log_b0[(bl+cnt) & 1023], remap(8'h0C, small_var));
  endtask

  initial begin
    int bl, bw, bd;
    void'($urandom(32'd4242));
    do_reset(1'b0, 10, 1'b0, 1'b1);
    run_scan(16'h0001, 1'b0, 1'b0);
    run_scan(16'hFFFF, 1'b0, 1'b0);
    run_scan(16'h8100, 1'b0, 1'b0);
    // R10 empty mask
    bl = n_log;
    run_scan(16'h0000, 1'b0, 1'b0);
    // R10 R11 mask change and trigger mid-scan ignored
    run_scan(16'h0A5C, 1'b1, 1'b0);
    for (int i = 0; i < 6; i++) run_scan(16'($urandom), 1'b0, 1'b0);
    // R8 timeout on second conversion
    bl = n_log; bw = n_w;
    drop_at = n_conv + 1;
    run_scan(16'h0007, 1'b0, 1'b1);
    drop_at = -1;
    chk(error == 1, "R8 timeout error", error, 1);
    chk(n_w - bw == 1 && w_idx[bw & 1023] == 4'd0, "R8 results before abort", n_w - bw, 1);
    chk(n_log - bl == 2, "R8 no transfer after abort", n_log - bl, 2);
    run_scan(16'h0030, 1'b0, 1'b0);
    // R2 acquisition variants and R5 small variant
    do_reset(1'b0, 0, 1'b0, 1'b1);
    do_reset(1'b0, 6, 1'b0, 1'b1);
    do_reset(1'b0, 18, 1'b0, 1'b1);
    do_reset(1'b1, 34, 1'b0, 1'b1);
    run_scan(16'hFFFF, 1'b0, 1'b0);
    for (int i = 0; i < 3; i++) run_scan(16'($urandom), 1'b0, 1'b0);
    // R2 invalid acquisition time
    do_reset(1'b0, 7, 1'b0, 1'b0);
    // R3 calibration still busy, triggers ignored
    do_reset(1'b0, 10, 1'b1, 1'b0);
    bl = n_log; bd = n_done;
    @(negedge clk); scan_mask = 16'h00FF; trigger = 1'b1;
    @(negedge clk); trigger = 1'b0;
    repeat (300) @(negedge clk);
    chk(n_log == bl && n_done == bd && busy == 0, "R3 trigger ignored after failure",
        n_log - bl, 0);
    $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
    $finish;
  end
endmodule